// File: doc/BRIEF.md
# Asymmetric Decode Slot Allocator

This block sits between an instruction queue and a bank of four decoders. Each cycle it looks at the oldest entries of the queue. Each entry is tagged with the number of micro-ops it expands into. The block decides how many leading entries can go to the decoders in that cycle. Slot 0 is a complex decoder that accepts an instruction of one to four micro-ops. Slots 1 to 3 are simple decoders and accept only single-micro-op instructions. A per-cycle micro-op budget caps the total that can be emitted. The parameter `WIDE_BUDGET` picks a budget of four (value 0) or five (value 1).

Placement follows program order and stops at the first entry that cannot be placed. That entry heads the window in a later cycle. The number of entries taken is offered combinationally on `pop_cnt`, and the queue removes that many entries at the same clock edge. The resulting group is registered and presented downstream. It is held there until `out_ready` is high.

A small state machine governs the output register. Its states are `ST_IDLE` (after reset, nothing presented), `ST_GROUP` (a decoded group is presented), `ST_STARVE` (the window was empty) and `ST_TRAP` (the head entry has an illegal micro-op count). Two transitions exist:
- Hold: from `ST_GROUP`, while `out_ready` is low, the state stays `ST_GROUP`.
- Reload: in every other case the next state is chosen from the current window, in this order: `ST_STARVE` if the window is empty, else `ST_TRAP` if the head is illegal, else `ST_GROUP`.

Top module: `decode_slot_alloc`

## Requirements
- R1: While and after reset, with no load since, `out_valid`, `out_stall` and `out_illegal` are 0, `out_take` is 0, and the slot mask and the per-slot micro-op fields are 0.
- R2: A legal head entry (micro-op count 1 to 4) always goes to slot 0, and `out_slot_uops` slot 0 carries its count.
- R3: Slots 1 to 3 take only entries whose count is exactly 1. Placement stops at the first entry that cannot be placed, and no later entry is taken in that cycle.
- R4: With `WIDE_BUDGET`=0 the micro-ops of a group never exceed 4. The head counts 1, 2, 3 and 4, each followed by single-op entries, give groups of 4, 3, 2 and 1 instructions.
- R5: With `WIDE_BUDGET`=1 the budget is 5. The head counts 2, 3 and 4, each followed by single-op entries, give groups of 4, 3 and 2 instructions. Five single-op entries still give only 4, because there are four slots.
- R6: The slot mask is contiguous from slot 0. `out_take` equals the number of set mask bits, and slots that are not taken show a count of 0.
- R7: Only the first `in_count` entries are considered. `pop_cnt` never exceeds `in_count`.
- R8: If the window is empty when the output register reloads, `out_stall` is 1 in the next cycle, `out_valid` is 0, and `pop_cnt` is 0.
- R9: A head entry whose count is 0 or greater than 4 is not consumed (`pop_cnt`=0), and `out_illegal` is 1 in the next cycle. An illegal entry behind the head ends the group in front of it.
- R10: While `out_valid` is 1 and `out_ready` is 0, all outputs keep their values and `pop_cnt` is 0.

Entry i of the window occupies `in_uops[3*i+2:3*i]`, and entry 0 is the oldest. Slot i of the output uses the same field layout in `out_slot_uops` and bit i of `out_slot_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_count | input | 3 | Number of valid entries in the window (0 to 4) |
| in_uops | input | 12 | Micro-op count per window entry, 3 bits each, entry 0 lowest |
| out_ready | input | 1 | Downstream accepts the presented group |
| pop_cnt | output | 3 | Entries removed from the queue at this clock edge |
| out_valid | output | 1 | A decoded group is presented |
| out_take | output | 3 | Number of instructions in the presented group |
| out_slot_vld | output | 4 | Per-slot occupancy of the presented group |
| out_slot_uops | output | 12 | Micro-op count per slot, 3 bits each |
| out_stall | output | 1 | The last reload found an empty window |
| out_illegal | output | 1 | The last reload found an illegal head entry |

## Verification
The bound checker checks the structural invariants of the presented group on every cycle. These are: the mask is contiguous, `out_take` agrees with the mask, the simple slots carry one micro-op each, the group stays within the budget, and at most one status flag is set. It also checks, on every cycle, that no entry is consumed when the window is empty or the head is illegal, and that outputs are held under back-pressure. The exact grouping for a given window cannot be expressed as a generic invariant. Only the bench scenarios show it: the narrow-versus-wide differences, the stop at a multi-op or illegal entry behind the head, and the limit set by `in_count`. The bench runs a narrow instance and a wide instance side by side to compare them.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    // Output-register states of the allocator
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GROUP  = 2'd1,
        ST_STARVE = 2'd2,
        ST_TRAP   = 2'd3
    } dsa_state_e;

endpackage

// File: rtl/dsa_legal.sv
// Per-entry classification of the instruction window.
module dsa_legal #(
    parameter int SLOTS    = 4,
    parameter int UW       = 3,
    parameter int MAX_UOPS = 4,
    parameter int CW       = 3
) (
    input  logic [CW-1:0]         in_count,
    input  logic [SLOTS*UW-1:0]   in_uops,
    output logic [SLOTS-1:0]      present,
    output logic [SLOTS-1:0]      legal,
    output logic [SLOTS-1:0]      single
);

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_entry
        logic [UW-1:0] cnt;
        assign cnt         = in_uops[gi*UW +: UW];
        assign present[gi] = (CW'(gi) < in_count);
        assign legal[gi]   = (cnt != '0) && (cnt <= UW'(MAX_UOPS));
        assign single[gi]  = (cnt == UW'(1));
    end

endmodule

// File: rtl/dsa_pack.sv
// In-order placement chain: slot 0 complex, remaining slots single-op only,
// bounded by the per-cycle micro-op budget.
module dsa_pack #(
    parameter int SLOTS  = 4,
    parameter int UW     = 3,
    parameter int BUDGET = 4,
    parameter int CW     = 3
) (
    input  logic [SLOTS-1:0]      present,
    input  logic [SLOTS-1:0]      legal,
    input  logic [SLOTS-1:0]      single,
    input  logic [SLOTS*UW-1:0]   in_uops,
    output logic [SLOTS-1:0]      take_mask,
    output logic [CW-1:0]         take_cnt,
    output logic                  head_bad,
    output logic                  win_empty
);

    localparam int BW = $clog2(BUDGET + 1) + 1;

    // budget left after each placed slot (last slot needs none)
    logic [BW-1:0] left_q [SLOTS-1];

    assign win_empty    = ~present[0];
    assign head_bad     = present[0] & ~legal[0];
    assign take_mask[0] = present[0] & legal[0];
    assign left_q[0]    = BW'(BUDGET) - BW'(in_uops[UW-1:0]);

    for (genvar gi = 1; gi < SLOTS; gi++) begin : g_chain
        assign take_mask[gi] = take_mask[gi-1] & present[gi] & legal[gi]
                             & single[gi] & (left_q[gi-1] != '0);
        if (gi < SLOTS - 1) begin : g_left
            assign left_q[gi] = left_q[gi-1] - BW'(1);
        end
    end

    always_comb begin
        take_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            take_cnt = take_cnt + CW'(take_mask[i]);
        end
    end

endmodule

// File: rtl/dsa_out_stage.sv
// Output register and its state machine.
module dsa_out_stage
    import dsa_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int UW    = 3,
    parameter int CW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  out_ready,
    input  logic                  win_empty,
    input  logic                  head_bad,
    input  logic [SLOTS-1:0]      take_mask,
    input  logic [CW-1:0]         take_cnt,
    input  logic [SLOTS*UW-1:0]   in_uops,
    output logic [CW-1:0]         pop_cnt,
    output logic [CW-1:0]         out_take,
    output logic [SLOTS-1:0]      out_slot_vld,
    output logic [SLOTS*UW-1:0]   out_slot_uops,
    output logic                  out_valid,
    output logic                  out_stall,
    output logic                  out_illegal
);

    dsa_state_e state_q, state_d, pick;
    logic load;
    logic [SLOTS*UW-1:0] masked_uops;

    assign load = (state_q != ST_GROUP) || out_ready;

    always_comb begin
        if (win_empty)     pick = ST_STARVE;
        else if (head_bad) pick = ST_TRAP;
        else               pick = ST_GROUP;
    end

    always_comb begin
        unique case (state_q)
            ST_GROUP:  state_d = out_ready ? pick : ST_GROUP;
            ST_IDLE:   state_d = pick;
            ST_STARVE: state_d = pick;
            ST_TRAP:   state_d = pick;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            masked_uops[i*UW +: UW] = take_mask[i] ? in_uops[i*UW +: UW] : '0;
        end
    end

    // output data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_take      <= '0;
            out_slot_vld  <= '0;
            out_slot_uops <= '0;
        end else if (load) begin
            if (pick == ST_GROUP) begin
                out_take      <= take_cnt;
                out_slot_vld  <= take_mask;
                out_slot_uops <= masked_uops;
            end else begin
                out_take      <= '0;
                out_slot_vld  <= '0;
                out_slot_uops <= '0;
            end
        end
    end

    assign pop_cnt     = (load && pick == ST_GROUP) ? take_cnt : '0;
    assign out_valid   = (state_q == ST_GROUP);
    assign out_stall   = (state_q == ST_STARVE);
    assign out_illegal = (state_q == ST_TRAP);

endmodule

// File: rtl/decode_slot_alloc.sv
// Asymmetric decode slot allocator (top).
module decode_slot_alloc #(
    parameter int SLOTS       = 4,
    parameter int UW          = 3,
    parameter int MAX_UOPS    = 4,
    parameter bit WIDE_BUDGET = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [$clog2(SLOTS+1)-1:0]         in_count,
    input  logic [SLOTS*UW-1:0]                in_uops,
    input  logic                               out_ready,
    output logic [$clog2(SLOTS+1)-1:0]         pop_cnt,
    output logic                               out_valid,
    output logic [$clog2(SLOTS+1)-1:0]         out_take,
    output logic [SLOTS-1:0]                   out_slot_vld,
    output logic [SLOTS*UW-1:0]                out_slot_uops,
    output logic                               out_stall,
    output logic                               out_illegal
);

    localparam int CW     = $clog2(SLOTS + 1);
    localparam int BUDGET = MAX_UOPS + (WIDE_BUDGET ? 1 : 0);

    logic [SLOTS-1:0] present, legal, single, take_mask;
    logic [CW-1:0]    take_cnt;
    logic             head_bad, win_empty;

    dsa_legal #(.SLOTS(SLOTS), .UW(UW), .MAX_UOPS(MAX_UOPS), .CW(CW)) u_legal (
        .in_count (in_count),
        .in_uops  (in_uops),
        .present  (present),
        .legal    (legal),
        .single   (single)
    );

    dsa_pack #(.SLOTS(SLOTS), .UW(UW), .BUDGET(BUDGET), .CW(CW)) u_pack (
        .present   (present),
        .legal     (legal),
        .single    (single),
        .in_uops   (in_uops),
        .take_mask (take_mask),
        .take_cnt  (take_cnt),
        .head_bad  (head_bad),
        .win_empty (win_empty)
    );

    dsa_out_stage #(.SLOTS(SLOTS), .UW(UW), .CW(CW)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .out_ready     (out_ready),
        .win_empty     (win_empty),
        .head_bad      (head_bad),
        .take_mask     (take_mask),
        .take_cnt      (take_cnt),
        .in_uops       (in_uops),
        .pop_cnt       (pop_cnt),
        .out_take      (out_take),
        .out_slot_vld  (out_slot_vld),
        .out_slot_uops (out_slot_uops),
        .out_valid     (out_valid),
        .out_stall     (out_stall),
        .out_illegal   (out_illegal)
    );

endmodule

// File: rtl/dsa_check.sv
// Property checker, bound to every decode_slot_alloc instance.
module dsa_check #(
    parameter int SLOTS       = 4,
    parameter int UW          = 3,
    parameter int MAX_UOPS    = 4,
    parameter bit WIDE_BUDGET = 1'b0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [$clog2(SLOTS+1)-1:0]    in_count,
    input logic [SLOTS*UW-1:0]           in_uops,
    input logic                          out_ready,
    input logic [$clog2(SLOTS+1)-1:0]    pop_cnt,
    input logic                          out_valid,
    input logic [$clog2(SLOTS+1)-1:0]    out_take,
    input logic [SLOTS-1:0]              out_slot_vld,
    input logic [SLOTS*UW-1:0]           out_slot_uops,
    input logic                          out_stall,
    input logic                          out_illegal
);

    localparam int BUDGET = MAX_UOPS + (WIDE_BUDGET ? 1 : 0);

    logic [7:0]    uop_sum;
    logic [UW-1:0] head_cnt, slot0_cnt;
    logic          head_illegal, may_load;

    always_comb begin
        uop_sum = '0;
        for (int i = 0; i < SLOTS; i++) begin
            uop_sum = uop_sum + 8'(out_slot_uops[i*UW +: UW]);
        end
    end

    assign head_cnt     = in_uops[UW-1:0];
    assign slot0_cnt    = out_slot_uops[UW-1:0];
    assign head_illegal = (in_count != '0) && ((head_cnt == '0) || (head_cnt > UW'(MAX_UOPS)));
    assign may_load     = !out_valid || out_ready;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_stall && !out_illegal && out_slot_vld == '0));

    assert_head_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot_vld[0] && slot0_cnt != '0 && slot0_cnt <= UW'(MAX_UOPS)));

    for (genvar gi = 1; gi < SLOTS; gi++) begin : g_simple
        assert_simple_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_slot_vld[gi] |-> (out_slot_uops[gi*UW +: UW] == UW'(1)));
    end

    // covers R5 as well when WIDE_BUDGET is set
    assert_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uop_sum <= 8'(BUDGET));

    assert_mask_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_slot_vld & (out_slot_vld + 1'b1)) == '0) &&
        ($countones(out_slot_vld) == int'(out_take)));

    assert_one_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_stall, out_illegal}));

    assert_window_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_cnt <= in_count);

    assert_starve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_count == '0 && may_load) |=> (out_stall && !out_valid));

    assert_illegal_nopop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        head_illegal |-> (pop_cnt == '0));

    assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (head_illegal && may_load) |=> out_illegal);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_take) &&
                                       $stable(out_slot_vld) && $stable(out_slot_uops)));

    assert_hold_nopop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (pop_cnt == '0));

endmodule

bind decode_slot_alloc dsa_check #(
    .SLOTS(SLOTS), .UW(UW), .MAX_UOPS(MAX_UOPS), .WIDE_BUDGET(WIDE_BUDGET)
) u_chk (.*);

// File: tb/sim_decode_slot_alloc.sv
`timescale 1ns/1ps
module sim_decode_slot_alloc;

    typedef struct packed {
        logic        valid;
        logic        stall;
        logic        ill;
        logic [2:0]  take;
        logic [3:0]  mask;
        logic [11:0] uops;
    } exp_t;

    typedef struct {
        exp_t  n;
        exp_t  w;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  in_count = '0;
    logic [11:0] in_uops = '0;
    logic        out_ready = 1'b1;

    logic [2:0]  pop_n, take_n, pop_w, take_w;
    logic [3:0]  vld_n, vld_w;
    logic [11:0] su_n, su_w;
    logic        val_n, stl_n, ill_n, val_w, stl_w, ill_w;

    int checks = 0;
    int fails  = 0;
    item_t q[$];
    exp_t  prev_n = '0;
    exp_t  prev_w = '0;

    always #10 clk = ~clk;

    decode_slot_alloc #(.WIDE_BUDGET(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_uops(in_uops),
        .out_ready(out_ready), .pop_cnt(pop_n), .out_valid(val_n), .out_take(take_n),
        .out_slot_vld(vld_n), .out_slot_uops(su_n), .out_stall(stl_n), .out_illegal(ill_n)
    );

    decode_slot_alloc #(.WIDE_BUDGET(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_uops(in_uops),
        .out_ready(out_ready), .pop_cnt(pop_w), .out_valid(val_w), .out_take(take_w),
        .out_slot_vld(vld_w), .out_slot_uops(su_w), .out_stall(stl_w), .out_illegal(ill_w)
    );

    function automatic logic [11:0] win(int a, int b, int c, int d);
        return {3'(d), 3'(c), 3'(b), 3'(a)};
    endfunction

    // expected group from the requirements
    function automatic exp_t model(int budget, int cnt, logic [11:0] u);
        exp_t e;
        int left;
        bit go;
        e = '0;
        if (cnt == 0) begin
            e.stall = 1'b1;
        end else if (u[2:0] == 3'd0 || u[2:0] > 3'd4) begin
            e.ill = 1'b1;
        end else begin
            e.valid = 1'b1;
            e.take = 3'd1;
            e.mask[0] = 1'b1;
            e.uops[2:0] = u[2:0];
            left = budget - int'(u[2:0]);
            go = 1'b1;
            for (int i = 1; i < 4; i++) begin
                if (go && i < cnt && u[i*3 +: 3] == 3'd1 && left > 0) begin
                    e.take = e.take + 3'd1;
                    e.mask[i] = 1'b1;
                    e.uops[i*3 +: 3] = 3'd1;
                    left = left - 1;
                end else begin
                    go = 1'b0;
                end
            end
        end
        return e;
    endfunction

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: apply one window, check pop count, push the expected registered result
    task automatic step(int cnt, logic [11:0] u, logic rdy, string tag);
        item_t it;
        exp_t nn, nw;
        logic ld_n, ld_w;
        @(negedge clk);
        in_count  = 3'(cnt);
        in_uops   = u;
        out_ready = rdy;
        #1;
        ld_n = !prev_n.valid || rdy;
        ld_w = !prev_w.valid || rdy;
        nn = ld_n ? model(4, cnt, u) : prev_n;
        nw = ld_w ? model(5, cnt, u) : prev_w;
        check_eq(tag, "pop narrow", 32'(pop_n), (ld_n && nn.valid) ? 32'(nn.take) : 32'd0);
        check_eq(tag, "pop wide",   32'(pop_w), (ld_w && nw.valid) ? 32'(nw.take) : 32'd0);
        it.n = nn;
        it.w = nw;
        it.tag = tag;
        q.push_back(it);
        prev_n = nn;
        prev_w = nw;
    endtask

    // monitor: compare registered outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check_eq(it.tag, "narrow out", 32'({val_n, stl_n, ill_n, take_n, vld_n, su_n}), 32'(it.n));
                check_eq(it.tag, "wide out",   32'({val_w, stl_w, ill_w, take_w, vld_w, su_w}), 32'(it.w));
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check_eq("R1", "reset narrow", 32'({val_n, stl_n, ill_n, take_n, vld_n, su_n}), 32'd0);
        check_eq("R1", "reset wide",   32'({val_w, stl_w, ill_w, take_w, vld_w, su_w}), 32'd0);
        check_eq("R1", "reset pop",    32'({pop_n, pop_w}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        step(4, win(1, 1, 1, 1), 1'b1, "R5 four singles, four slots");
        step(4, win(2, 1, 1, 1), 1'b1, "R4 head two");
        step(4, win(3, 1, 1, 1), 1'b1, "R4 head three");
        step(4, win(4, 1, 1, 1), 1'b1, "R4 head four");
        step(4, win(1, 2, 1, 1), 1'b1, "R3 multi-op behind head");
        step(4, win(1, 1, 3, 1), 1'b1, "R3 stop at third entry");
        step(4, win(2, 1, 4, 1), 1'b1, "R3 later entry not taken");
        step(2, win(1, 1, 1, 1), 1'b1, "R7 window of two");
        step(1, win(4, 1, 1, 1), 1'b1, "R7 window of one");
        step(0, win(1, 1, 1, 1), 1'b1, "R8 empty window");
        step(4, win(0, 1, 1, 1), 1'b1, "R9 zero-op head");
        step(4, win(5, 1, 1, 1), 1'b1, "R9 five-op head");
        step(4, win(1, 7, 1, 1), 1'b1, "R9 illegal behind head");
        step(3, win(2, 1, 1, 1), 1'b1, "R6 partial group");
        step(4, win(3, 1, 1, 1), 1'b0, "R10 load then stall downstream");
        step(4, win(1, 1, 1, 1), 1'b0, "R10 held");
        step(0, win(0, 0, 0, 0), 1'b0, "R10 held with empty window");
        step(4, win(1, 1, 1, 1), 1'b1, "R10 release");
        step(4, win(2, 1, 1, 1), 1'b1, "R2 head two after release");

        repeat (3) @(negedge clk);
        check_eq("R1", "scoreboard drained", 32'(q.size()), 32'd0);
        finish_run();
    end

endmodule